// File: doc/BRIEF.md
# Dual-Slot Input Capture Unit

This block sits beside a free-running 32-bit timer counter and records the counter value when a chosen transition occurs on an external pin. The pin is brought into the clock domain through a synchronizer chain, and a transition is recognised by comparing the newest synchronized sample with the one before it. Software picks which transitions count (none, rising, falling or both) and must set the pin as an input before anything is recorded.

Two capture slots are filled in strict order: the first qualifying transition writes the first slot, the second writes the second slot, and any later transition is dropped until the unit is rearmed. A select bit decides whether the one-cycle capture event marks the first or the second capture. Rearming comes either from a clear strobe (driven when software clears the capture status flag) or from switching the edge mode from none to an active mode.

Top module: `dual_capture_unit`

## Requirements
- R1: `edge_mode` encodes 0 = no capture, 1 = rising (low to high), 2 = falling (high to low), 3 = either transition of the synchronized pin; with mode 0 no slot changes and no event is raised.
- R2: A transition is recorded only while `pin_is_input` is 1; while it is 0 both slots hold their values and no event is raised.
- R3: The first recorded transition after rearm writes `cap_first` and the second writes `cap_second`; the stored value is `count_in` in the cycle the transition is detected, and it appears on the output one cycle later. A transition on `pin_in` sampled at clock edge k is detected in the cycle after edge k+1 (two synchronizer stages plus one history stage).
- R4: After two recordings, further qualifying transitions change neither slot and raise no event until the unit is rearmed.
- R5: `cap_event` is a one-cycle pulse, high in the cycle a new slot value first appears; with `evt_on_second` = 0 it marks the first recording, with 1 the second, judged by the select value in the cycle of detection.
- R6: A cycle with `rearm` = 1 resets the recording count to zero; a transition detected in that same cycle is dropped.
- R7: A change of `edge_mode` from 0 to any non-zero value (compared with its value in the previous cycle) resets the recording count like `rearm`, and a transition detected in that cycle is dropped.
- R8: During reset both slots read 0, `cap_event` is 0 and the recording count is zero; the synchronizer and history stages hold 0, and `edge_mode` is taken as 0 before the first cycle.
- R9: Rearming does not alter the values held in the two slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 1 | Asynchronous capture pin |
| count_in | input | CNT_W | Current timer counter value |
| edge_mode | input | 2 | Transition selection (0 none, 1 rising, 2 falling, 3 both) |
| pin_is_input | input | 1 | 1 when the pin is configured as an input |
| evt_on_second | input | 1 | 0: event on first recording, 1: event on second |
| rearm | input | 1 | One-cycle strobe resetting the recording count |
| cap_first | output | CNT_W | First capture slot |
| cap_second | output | CNT_W | Second capture slot |
| cap_event | output | 1 | One-cycle capture event |

## Verification
The properties assume `rearm`, `edge_mode`, `pin_is_input` and `evt_on_second` are synchronous to `clk` and settle before each rising edge, and that `pin_in` changes no faster than once per cycle so the synchronizer chain sees every level. The stimulus drives all inputs on the falling edge only, holds each pin level for at least one full cycle, and lines rearm strobes and mode changes up with detection cycles on purpose so that the dropped-transition cases of R6 and R7 are exercised.

// File: rtl/dcap_pkg.sv
package dcap_pkg;
   typedef enum logic [1:0] {
      EDGE_OFF  = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2,
      EDGE_ANY  = 2'd3
   } edge_sel_e;

   localparam int unsigned NUM_SLOTS = 2;
   localparam int unsigned SLOT_IDX_W = 2;
endpackage

// File: rtl/dcap_sync.sv
module dcap_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RST_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   localparam int unsigned LAST = STAGES - 1;

   logic [STAGES-1:0] stg_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("dcap_sync needs at least two stages");
      end
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (!rst_n) stg_q[g] <= RST_LEVEL;
               else        stg_q[g] <= din;
            end
         end else begin : g_tail
            always_ff @(posedge clk) begin
               if (!rst_n) stg_q[g] <= RST_LEVEL;
               else        stg_q[g] <= stg_q[g-1];
            end
         end
      end
   endgenerate

   assign dout = stg_q[LAST];
endmodule

// File: rtl/dcap_edge_qual.sv
module dcap_edge_qual
   import dcap_pkg::*;
#(
   parameter bit RST_LEVEL = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      smp,
   input  edge_sel_e mode,
   output logic      hit
);
   logic prev_q;
   logic rose;
   logic fell;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= RST_LEVEL;
      else        prev_q <= smp;
   end

   assign rose = smp & ~prev_q;
   assign fell = ~smp & prev_q;

   always_comb begin
      unique case (mode)
         EDGE_RISE: hit = rose;
         EDGE_FALL: hit = fell;
         EDGE_ANY:  hit = rose | fell;
         default:   hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/dcap_slot_ctrl.sv
module dcap_slot_ctrl
   import dcap_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic             dir_in,
   input  logic             sel_second,
   input  logic             rearm,
   input  edge_sel_e        mode,
   input  logic [CNT_W-1:0] count_in,
   output logic [CNT_W-1:0] slot0,
   output logic [CNT_W-1:0] slot1,
   output logic             evt
);
   localparam logic [SLOT_IDX_W-1:0] FULL = SLOT_IDX_W'(NUM_SLOTS);

   edge_sel_e              mode_prev_q;
   logic [SLOT_IDX_W-1:0]  used_q;
   logic                   arm_now;
   logic                   take;
   logic                   evt_q;
   logic [CNT_W-1:0]       slot_q [NUM_SLOTS];
   logic [SLOT_IDX_W-1:0]  evt_idx;

   assign arm_now = rearm | ((mode_prev_q == EDGE_OFF) && (mode != EDGE_OFF));
   assign take    = hit & dir_in & ~arm_now & (used_q < FULL);
   assign evt_idx = sel_second ? SLOT_IDX_W'(1) : SLOT_IDX_W'(0);

   always_ff @(posedge clk) begin
      if (!rst_n) mode_prev_q <= EDGE_OFF;
      else        mode_prev_q <= mode;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       used_q <= '0;
      else if (arm_now) used_q <= '0;
      else if (take)    used_q <= used_q + SLOT_IDX_W'(1);
   end

   generate
      for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n)
               slot_q[g] <= '0;
            else if (take && (used_q == SLOT_IDX_W'(g)))
               slot_q[g] <= count_in;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) evt_q <= 1'b0;
      else        evt_q <= take && (used_q == evt_idx);
   end

   assign slot0 = slot_q[0];
   assign slot1 = slot_q[1];
   assign evt   = evt_q;
endmodule

// File: rtl/dual_capture_unit.sv
module dual_capture_unit
   import dcap_pkg::*;
#(
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          PIN_IDLE    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_in,
   input  logic [CNT_W-1:0] count_in,
   input  logic [1:0]       edge_mode,
   input  logic             pin_is_input,
   input  logic             evt_on_second,
   input  logic             rearm,
   output logic [CNT_W-1:0] cap_first,
   output logic [CNT_W-1:0] cap_second,
   output logic             cap_event
);
   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("dual_capture_unit: CNT_W must be positive");
      end
      if (NUM_SLOTS != 2) begin : g_bad_slots
         $error("dual_capture_unit: exactly two slots are supported");
      end
   endgenerate

   edge_sel_e mode_e;
   logic      pin_sync;
   logic      edge_hit;

   assign mode_e = edge_sel_e'(edge_mode);

   dcap_sync #(
      .STAGES   (SYNC_STAGES),
      .RST_LEVEL(PIN_IDLE)
   ) u_sync (
      .clk (clk),
      .rst_n(rst_n),
      .din (pin_in),
      .dout(pin_sync)
   );

   dcap_edge_qual #(
      .RST_LEVEL(PIN_IDLE)
   ) u_qual (
      .clk  (clk),
      .rst_n(rst_n),
      .smp  (pin_sync),
      .mode (mode_e),
      .hit  (edge_hit)
   );

   dcap_slot_ctrl #(
      .CNT_W(CNT_W)
   ) u_slots (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (edge_hit),
      .dir_in    (pin_is_input),
      .sel_second(evt_on_second),
      .rearm     (rearm),
      .mode      (mode_e),
      .count_in  (count_in),
      .slot0     (cap_first),
      .slot1     (cap_second),
      .evt       (cap_event)
   );
endmodule

// File: rtl/dcap_checker.sv
module dcap_checker #(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       edge_mode,
   input logic             pin_is_input,
   input logic             rearm,
   input logic [CNT_W-1:0] cap_first,
   input logic [CNT_W-1:0] cap_second,
   input logic             cap_event
);
   // R2 and R1: an event needs the pin as input and an active mode one cycle earlier
   p_event_needs_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cap_event |-> ($past(pin_is_input) && ($past(edge_mode) != 2'd0)));

   p_hold_when_output_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_is_input |=> ($stable(cap_first) && $stable(cap_second)));

   p_one_slot_per_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cap_second) |-> $stable(cap_first));

   // R6 and R9: a rearm cycle records nothing and keeps the stored values
   p_rearm_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rearm |=> ($stable(cap_first) && $stable(cap_second) && !cap_event));

   p_mode_off_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode == 2'd0) |=> ($stable(cap_first) && $stable(cap_second) && !cap_event));
endmodule

bind dual_capture_unit dcap_checker #(.CNT_W(CNT_W)) u_dcap_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .edge_mode   (edge_mode),
   .pin_is_input(pin_is_input),
   .rearm       (rearm),
   .cap_first   (cap_first),
   .cap_second  (cap_second),
   .cap_event   (cap_event)
);

// File: tb/dual_capture_unit_bench.sv
module dual_capture_unit_bench;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         pin_in = 1'b0;
   logic [W-1:0] count_in = '0;
   logic [1:0]   edge_mode = 2'd0;
   logic         pin_is_input = 1'b0;
   logic         evt_on_second = 1'b0;
   logic         rearm = 1'b0;
   logic [W-1:0] cap_first;
   logic [W-1:0] cap_second;
   logic         cap_event;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   dual_capture_unit u_dual_capture_unit (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .count_in(count_in),
      .edge_mode(edge_mode), .pin_is_input(pin_is_input),
      .evt_on_second(evt_on_second), .rearm(rearm),
      .cap_first(cap_first), .cap_second(cap_second), .cap_event(cap_event)
   );

   // behavioural reference model
   int          hist[$] = '{0, 0, 0};
   int          m_used = 0;
   int          m_mode_prev = 0;
   logic [W-1:0] m_c1 = '0;
   logic [W-1:0] m_c2 = '0;
   bit          m_ev = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         hist = '{0, 0, 0};
         m_used = 0; m_mode_prev = 0; m_c1 = '0; m_c2 = '0; m_ev = 1'b0;
      end else begin
         bit up, down, hit, arm;
         up   = (hist[1] == 1) && (hist[2] == 0);
         down = (hist[1] == 0) && (hist[2] == 1);
         hit  = (edge_mode == 2'd1 && up) || (edge_mode == 2'd2 && down) ||
                (edge_mode == 2'd3 && (up || down));
         arm  = rearm || (m_mode_prev == 0 && edge_mode != 2'd0);
         m_ev = 1'b0;
         if (arm) m_used = 0;
         else if (hit && pin_is_input && m_used < 2) begin
            if (m_used == 0) m_c1 = count_in; else m_c2 = count_in;
            if (m_used == int'(evt_on_second)) m_ev = 1'b1;
            m_used++;
         end
         hist.push_front(int'(pin_in));
         void'(hist.pop_back());
         m_mode_prev = int'(edge_mode);
      end
   end

   task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%h expected=%h at %0t", tag, got, exp, $time);
      end
   endtask

   // every-cycle comparison (R3 slots, R5 event)
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check("R3 cap_first", cap_first, m_c1);
         check("R3 cap_second", cap_second, m_c2);
         check("R5 cap_event", W'(cap_event), W'(m_ev));
      end
      count_in <= count_in + W'(7);
   end

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic set_pin(logic v);
      @(negedge clk); pin_in = v; idle(4);
   endtask

   logic [W-1:0] snap1, snap2;

   initial begin
      idle(3);
      // R8: reset values
      check("R8 reset cap_first", cap_first, '0);
      check("R8 reset cap_second", cap_second, '0);
      check("R8 reset cap_event", W'(cap_event), '0);
      @(negedge clk); rst_n = 1'b1; idle(2);

      // R1 rising mode, R3 order, R5 event on first
      pin_is_input = 1'b1; edge_mode = 2'd1; evt_on_second = 1'b0; idle(2);
      set_pin(1'b1); set_pin(1'b0); set_pin(1'b1);
      check("R3 first slot filled", W'(cap_first != 0), W'(1));
      check("R3 second slot filled", W'(cap_second != 0), W'(1));
      // R4: further edges ignored
      snap1 = cap_first; snap2 = cap_second;
      set_pin(1'b0); set_pin(1'b1);
      check("R4 first held", cap_first, snap1);
      check("R4 second held", cap_second, snap2);

      // R6 rearm, R9 values kept
      @(negedge clk); rearm = 1'b1; @(negedge clk); rearm = 1'b0;
      check("R9 first kept", cap_first, snap1);
      check("R9 second kept", cap_second, snap2);

      // R1 falling mode with event on second (R5)
      edge_mode = 2'd2; evt_on_second = 1'b1;
      set_pin(1'b0); set_pin(1'b1); set_pin(1'b0);

      // R1 both mode after rearm
      @(negedge clk); rearm = 1'b1; edge_mode = 2'd3; evt_on_second = 1'b0;
      @(negedge clk); rearm = 1'b0;
      set_pin(1'b1); set_pin(1'b0);

      // R2: pin as output, edges ignored
      @(negedge clk); rearm = 1'b1; @(negedge clk); rearm = 1'b0;
      pin_is_input = 1'b0; snap1 = cap_first; snap2 = cap_second;
      set_pin(1'b1); set_pin(1'b0);
      check("R2 first untouched", cap_first, snap1);
      check("R2 second untouched", cap_second, snap2);
      pin_is_input = 1'b1;

      // R1 mode none: nothing recorded
      edge_mode = 2'd0; set_pin(1'b1); set_pin(1'b0);
      check("R1 none first", cap_first, snap1);
      // R7: leaving none rearms without a strobe
      edge_mode = 2'd1; idle(1);
      set_pin(1'b1);
      check("R7 rearmed by mode", W'(cap_first != snap1), W'(1));

      // R6: rearm coincident with detection drops the edge
      @(negedge clk); rearm = 1'b1; @(negedge clk); rearm = 1'b0;
      set_pin(1'b0);
      snap1 = cap_first;
      @(negedge clk); pin_in = 1'b1;
      @(negedge clk); @(negedge clk); rearm = 1'b1;
      @(negedge clk); rearm = 1'b0; idle(2);
      check("R6 edge dropped", cap_first, snap1);

      // R7: mode change coincident with detection drops the edge
      edge_mode = 2'd0; idle(2);
      @(negedge clk); pin_in = 1'b0;
      @(negedge clk); @(negedge clk); edge_mode = 2'd3;
      idle(3);
      check("R7 edge dropped", cap_first, snap1);

      // back-to-back toggles in both mode (R4 limit)
      for (int k = 0; k < 6; k++) begin @(negedge clk); pin_in = ~pin_in; end
      idle(5);

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule